// File: doc/BRIEF.md
# Radio Power and Antenna Switch Controller

This block turns the link controller's current frame type into the static control lines of an external frequency-hopping radio transceiver. A two-bit frame code selects idle, transmit or receive. In each mode the block powers only the radio sections that the frame needs. It also sets the synthesizer loop open or closed, steers the antenna switch, gates the external power amplifier, and runs a reference-oscillator output only while the radio is enabled.

Two configuration inputs refine the drive. The first, `loop_open_rx_i`, opens the synthesizer loop during receive frames as well. In transmit frames the loop is always open so that the VCO can be modulated directly. The second, `hi_pwr_i`, selects the high-output-power class, which needs the external amplifier during transmit. Every output comes from a flop, so a new frame code or configuration shows at the pins one clock edge after it is applied.

Top module: `rf_power_ctrl`

## Requirements
- R1: Frame code encoding on `frame_i`: 2'b00 idle, 2'b01 transmit, 2'b10 receive. `tx_pd_o` is low (transmitter powered) only in transmit and high in every other mode.
- R2: `rx_pd_o` is low (receiver powered) only in receive and high in every other mode.
- R3: `pll_pd_o` is high (loop open) in every transmit frame, whatever the value of `loop_open_rx_i`.
- R4: In receive, `pll_pd_o` equals `loop_open_rx_i`. In idle, `pll_pd_o` is low.
- R5: `chip_en_o` is low in idle and high in transmit and receive.
- R6: `ant_sw_a_o` is high in transmit only, and `ant_sw_b_o` is always its inverse, including during reset.
- R7: `pa_en_o` is high only when `hi_pwr_i` is high and the mode is transmit.
- R8: `ref_osc_o` is low and static whenever `chip_en_o` is low. While the radio is enabled it toggles once every `REF_HALF` clock cycles.
- R9: The unused frame code 2'b11 drives every output exactly as idle does.
- R10: While reset is held, the outputs read tx_pd=1, rx_pd=1, pll_pd=0, chip_en=0, ant_a=0, ant_b=1, pa_en=0, ref_osc=0. Any input change appears on the outputs at the first rising clock edge after it.
- R11: `tx_pd_o` and `rx_pd_o` are never low at the same time, including on a direct switch between transmit and receive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 2 | Frame code: 00 idle, 01 transmit, 10 receive, 11 treated as idle |
| loop_open_rx_i | input | 1 | Open the synthesizer loop during receive frames |
| hi_pwr_i | input | 1 | High-power class select |
| tx_pd_o | output | 1 | Transmitter power-down, high = off |
| rx_pd_o | output | 1 | Receiver power-down, high = off |
| pll_pd_o | output | 1 | Synthesizer power-down / loop open, high = open |
| chip_en_o | output | 1 | Radio chip enable, high = enabled |
| ant_sw_a_o | output | 1 | Antenna switch line, high in transmit |
| ant_sw_b_o | output | 1 | Antenna switch line, inverse of ant_sw_a_o |
| pa_en_o | output | 1 | External power amplifier enable |
| ref_osc_o | output | 1 | Gated reference oscillator output |

## Verification
The hardest case to reach from the ports is a switch from transmit straight to receive, or back, with no idle frame in between. Such a switch could let both power-downs be low in the same cycle, and it also exercises the loop line under both settings of the receive configuration bit. The stimulus chains these back-to-back switches and also moves through the unused code 2'b11. Each code is held long enough to watch the reference output start, run and stop with the chip enable.

// File: rtl/rf_power_pkg.sv
package rf_power_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE = 2'b00,
        MODE_TX   = 2'b01,
        MODE_RX   = 2'b10,
        MODE_RSVD = 2'b11
    } frame_mode_e;

    typedef struct packed {
        logic tx_pd;
        logic rx_pd;
        logic pll_pd;
        logic chip_en;
        logic ant_a;
        logic pa_en;
    } radio_lines_t;

    localparam radio_lines_t LINES_RESET = '{
        tx_pd: 1'b1, rx_pd: 1'b1, pll_pd: 1'b0,
        chip_en: 1'b0, ant_a: 1'b0, pa_en: 1'b0
    };

endpackage

// File: rtl/rf_mode_decode.sv
module rf_mode_decode
    import rf_power_pkg::*;
(
    input  logic [1:0]  frame_i,
    output frame_mode_e mode_o
);
    always_comb begin
        unique case (frame_i)
            2'b01:   mode_o = MODE_TX;
            2'b10:   mode_o = MODE_RX;
            default: mode_o = MODE_IDLE;
        endcase
    end
endmodule

// File: rtl/rf_ref_osc.sv
module rf_ref_osc #(
    parameter int REF_HALF = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic active_d_i,
    input  logic active_q_i,
    output logic osc_o
);
    localparam int CW = (REF_HALF > 1) ? $clog2(REF_HALF) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(REF_HALF - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          osc;
    } osc_state_t;

    osc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!active_d_i) begin
            st_d.cnt = '0;
            st_d.osc = 1'b0;
        end else if (st_q.cnt == CNT_LAST) begin
            st_d.cnt = '0;
            st_d.osc = ~st_q.osc;
        end else begin
            st_d.cnt = CW'(st_q.cnt + 1'b1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign osc_o = st_q.osc;

    // R8
    osc_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !active_q_i |-> !st_q.osc);
    // R8
    osc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (active_q_i && st_q.cnt != CNT_LAST && active_d_i) |=> $stable(st_q.osc));
endmodule

// File: rtl/rf_power_ctrl.sv
module rf_power_ctrl
    import rf_power_pkg::*;
#(
    parameter int REF_HALF = 2
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [1:0] frame_i,
    input  logic       loop_open_rx_i,
    input  logic       hi_pwr_i,
    output logic       tx_pd_o,
    output logic       rx_pd_o,
    output logic       pll_pd_o,
    output logic       chip_en_o,
    output logic       ant_sw_a_o,
    output logic       ant_sw_b_o,
    output logic       pa_en_o,
    output logic       ref_osc_o
);
    frame_mode_e  mode;
    radio_lines_t lines_d, lines_q;

    rf_mode_decode u_decode (
        .frame_i (frame_i),
        .mode_o  (mode)
    );

    always_comb begin
        lines_d = LINES_RESET;
        unique case (mode)
            MODE_TX: begin
                lines_d.tx_pd   = 1'b0;
                lines_d.pll_pd  = 1'b1;
                lines_d.chip_en = 1'b1;
                lines_d.ant_a   = 1'b1;
                lines_d.pa_en   = hi_pwr_i;
            end
            MODE_RX: begin
                lines_d.rx_pd   = 1'b0;
                lines_d.pll_pd  = loop_open_rx_i;
                lines_d.chip_en = 1'b1;
            end
            default: lines_d = LINES_RESET;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) lines_q <= LINES_RESET;
        else         lines_q <= lines_d;
    end

    rf_ref_osc #(.REF_HALF(REF_HALF)) u_ref_osc (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .active_d_i (lines_d.chip_en),
        .active_q_i (lines_q.chip_en),
        .osc_o      (ref_osc_o)
    );

    assign tx_pd_o    = lines_q.tx_pd;
    assign rx_pd_o    = lines_q.rx_pd;
    assign pll_pd_o   = lines_q.pll_pd;
    assign chip_en_o  = lines_q.chip_en;
    assign ant_sw_a_o = lines_q.ant_a;
    assign ant_sw_b_o = ~lines_q.ant_a;
    assign pa_en_o    = lines_q.pa_en;

    // R11
    no_dual_power_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_pd_o || rx_pd_o);
    // R6
    ant_complement_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ant_sw_a_o != ant_sw_b_o);
    // R7
    pa_needs_tx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pa_en_o |-> (!tx_pd_o && ant_sw_a_o));
    // R1
    tx_next_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (frame_i == 2'b01) |=> !tx_pd_o);
    // R3
    loop_open_tx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (frame_i == 2'b01) |=> pll_pd_o);
    // R5
    idle_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (frame_i == 2'b00 || frame_i == 2'b11) |=> (!chip_en_o && tx_pd_o && rx_pd_o));
endmodule

// File: tb/rf_power_ctrl_bench.sv
module rf_power_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int REF_HALF   = 2;

    typedef struct {
        logic [6:0] lines;
        string      tag;
    } exp_item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] frame = 2'b00;
    logic       loop_rx = 1'b0;
    logic       hi_pwr = 1'b0;
    logic tx_pd, rx_pd, pll_pd, chip_en, ant_a, ant_b, pa_en, ref_osc;

    int checks = 0;
    int fails  = 0;
    exp_item_t sb[$];
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rf_power_ctrl #(.REF_HALF(REF_HALF)) u_rf_power_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .frame_i(frame),
        .loop_open_rx_i(loop_rx), .hi_pwr_i(hi_pwr),
        .tx_pd_o(tx_pd), .rx_pd_o(rx_pd), .pll_pd_o(pll_pd),
        .chip_en_o(chip_en), .ant_sw_a_o(ant_a), .ant_sw_b_o(ant_b),
        .pa_en_o(pa_en), .ref_osc_o(ref_osc)
    );

    function automatic logic [6:0] observed();
        return {tx_pd, rx_pd, pll_pd, chip_en, ant_a, ant_b, pa_en};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Model built from the requirements: {tx_pd,rx_pd,pll_pd,chip_en,ant_a,ant_b,pa_en}
    task automatic drive(input logic [1:0] code, input logic lrx, input logic hp, input string tag);
        exp_item_t it;
        @(negedge clk);
        frame = code; loop_rx = lrx; hi_pwr = hp;
        case (code)
            2'b01:   it.lines = {1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, hp};
            2'b10:   it.lines = {1'b1, 1'b0, lrx, 1'b1, 1'b0, 1'b1, 1'b0};
            default: it.lines = {1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
        endcase
        it.tag = tag;
        sb.push_back(it);
    endtask

    // Monitor: one cycle after each push the registered outputs must match (R10)
    always @(posedge clk) begin
        #1;
        if (rst_n && sb.size() > 0) begin
            exp_item_t it;
            it = sb.pop_front();
            check(observed() == it.lines, it.tag, 32'(observed()), 32'(it.lines));
            check(tx_pd || rx_pd, "R11", {tx_pd, rx_pd}, 2'b11);
            check(ant_b == ~ant_a, "R6", ant_b, ~ant_a);
            if (!chip_en) check(ref_osc == 1'b0, "R8", ref_osc, 0);
        end
    end

    task automatic ref_run(input logic [1:0] code, input bit expect_run, input string tag);
        int toggles = 0;
        logic last;
        drive(code, 1'b0, 1'b0, tag);
        @(negedge clk);
        last = ref_osc;
        for (int i = 0; i < 8 * REF_HALF; i++) begin
            drive(code, 1'b0, 1'b0, tag);
            if (ref_osc != last) toggles++;
            last = ref_osc;
        end
        if (expect_run) check(toggles >= 7 && toggles <= 8, "R8 toggles", toggles, 8);
        else            check(toggles == 0, "R8 static", toggles, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        frame = 2'b01; hi_pwr = 1'b1;
        repeat (3) @(negedge clk);
        // R10 reset values, with transmit code applied during reset
        check(observed() == 7'b1100010, "R10 reset", 32'(observed()), 32'h62);
        check(ref_osc == 1'b0, "R10 reset ref", ref_osc, 0);
        frame = 2'b00; hi_pwr = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        drive(2'b00, 1'b0, 1'b0, "R5 idle");
        drive(2'b01, 1'b0, 1'b0, "R1 R3 tx low power");
        drive(2'b01, 1'b0, 1'b1, "R7 tx high power");
        drive(2'b01, 1'b1, 1'b1, "R3 tx loop cfg ignored");
        drive(2'b10, 1'b0, 1'b1, "R2 R4 rx loop closed R7");
        drive(2'b10, 1'b1, 1'b0, "R4 rx loop open");
        drive(2'b01, 1'b1, 1'b1, "R11 rx to tx");
        drive(2'b10, 1'b1, 1'b1, "R11 tx to rx");
        drive(2'b11, 1'b1, 1'b1, "R9 reserved code");
        drive(2'b01, 1'b0, 1'b1, "R1 tx after reserved");
        drive(2'b11, 1'b0, 1'b0, "R9 reserved after tx");
        drive(2'b00, 1'b1, 1'b1, "R4 R7 idle ignores cfg");
        drive(2'b10, 1'b0, 1'b0, "R2 rx");
        drive(2'b00, 1'b0, 1'b0, "R5 idle again");
        ref_run(2'b01, 1'b1, "R8 tx");
        ref_run(2'b00, 1'b0, "R8 idle");
        ref_run(2'b10, 1'b1, "R8 rx");
        ref_run(2'b11, 1'b0, "R8 R9 reserved");
        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R10 scoreboard drained", sb.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule